// File: doc/BRIEF.md
# Audio Frame Clock Generator

This block produces the bit clock and the word-select line of a serial audio link that carries two-channel I2S or multi-slot TDM frames. It runs entirely in the system clock domain. An external oversampling clock, a bit-clock pin and a word-select pin are brought in through synchronisers. When the block masters the bit clock, it divides the oversampling clock by a programmable ratio. When it does not, it follows the bit clock on the pin. Word select is handled the same way and is chosen on its own, so any of the four master and slave combinations can be used. The block also gives the data serializer one-cycle strobes for each sample edge, for each slot start and for each half-frame start, together with the current bit index, slot index and half-frame identity.

The length of a half-frame in bit clocks is set apart from the sample width, and each half-frame is split into equal slots. Either pin can be inverted. A burst option stops the mastered bit clock, at its inactive level, whenever the serializer has nothing to move. The control is a four-state machine. OFF holds everything idle. SYNC waits for the first word-select edge from outside. RUN is normal operation. HOLD is the bit clock parked by burst gating. Its transitions are: enable (OFF to RUN when word select is mastered, OFF to SYNC when it is followed), lock (SYNC to RUN on the first external word-select edge), park (RUN to HOLD when burst gating applies and the bit clock is low), resume (HOLD to RUN when data is requested again), and stop (any state to OFF when enable drops or the configuration is invalid).

Top module: `audio_frame_clkgen`

## Requirements
- R1: In bit-clock master mode, one bit-clock period equals N periods of the oversampling clock. N is 1, 2, 4, 8 or 16 for divider codes 0, 1, 2, 3 and 4.
- R2: The block raises cfg_err and stays idle while enabled when the configuration is invalid. Invalid means a divider code from 5 to 7, a word-length code of 7, or three slots per half-frame (channel code 2) with any half-frame length other than 48.
- R3: Half-frame length codes 0 to 6 select 8, 16, 32, 48, 64, 128 or 256 bit clocks per half-frame. When word select is mastered, ws_out toggles once per half-frame, and bit_idx runs from 0 to length−1.
- R4: Channel code c (2-bit) gives c+1 slots per half-frame, each of length/(c+1) bits. slot_start pulses at the first bit of every slot, slot_idx counts from 0 to c, and half_start never pulses without slot_start.
- R5: With sck_inv=0 the bit clock idles low and bits are sampled on its rising edge. With sck_inv=1 it idles high and bits are sampled on its falling edge. When bit_strobe pulses, sck_out equals the inverse of sck_inv.
- R6: With ws_inv=0 the first half-frame has ws_out high. With ws_inv=1 it has ws_out low. The idle level of ws_out is the first-half level.
- R7: With burst_en=1 in bit-clock master mode, the bit clock stays at its idle level and no bit_strobe pulses while data_req is low. It runs while data_req is high. With burst_en=0, data_req has no effect.
- R8: In bit-clock slave mode, sck_oe is low and sck_out holds its idle level. bit_strobe pulses once per sample edge of sck_in.
- R9: In word-select slave mode, ws_oe is low and nothing is strobed until the first edge of ws_in after enable. Every later ws_in edge reloads the counters to bit 0, and half_id reports the half-frame (0 at the first-half level).
- R10: While enable is low, sck_out and ws_out rest at their idle levels and no strobes occur. Enabling again in word-select master mode starts at bit 0 of the first half-frame, with half_id=0.
- R11: In word-select master mode, half_start pulses on the cycle ws_out changes and once when the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| div_code | input | 3 | Bit-clock divider code |
| swl_code | input | 3 | Half-frame length code |
| chan_code | input | 2 | Channel count code, channels/2 − 1 |
| sck_master | input | 1 | 1: drive the bit clock, 0: follow sck_in |
| ws_master | input | 1 | 1: drive word select, 0: follow ws_in |
| sck_inv | input | 1 | Bit-clock polarity |
| ws_inv | input | 1 | Word-select polarity |
| burst_en | input | 1 | Gate the mastered bit clock by data_req |
| data_req | input | 1 | Serializer has data to move |
| ovs_clk | input | 1 | External oversampling clock |
| sck_in | input | 1 | Bit clock from the pin |
| ws_in | input | 1 | Word select from the pin |
| sck_out | output | 1 | Bit clock to the pin |
| sck_oe | output | 1 | Bit-clock pin drive enable |
| ws_out | output | 1 | Word select to the pin |
| ws_oe | output | 1 | Word-select pin drive enable |
| cfg_err | output | 1 | Configuration is invalid |
| bit_strobe | output | 1 | One-cycle pulse per sample edge |
| slot_start | output | 1 | Pulse at the first bit of a slot |
| half_start | output | 1 | Pulse at the first bit of a half-frame |
| half_id | output | 1 | Current half-frame, 0 = first |
| slot_idx | output | 2 | Current slot within the half-frame |
| bit_idx | output | 8 | Current bit within the half-frame |

## Verification
The hardest condition to reach is the word-select slave lock. The state machine has to sit in SYNC while its own bit clock runs, and it must show no strobes at all. It then has to lock on an edge that the bench places at an arbitrary point in the bit-clock period. The bench parks ws_in at the first-half level across the enable, watches a long quiet window, and then flips the pin. Later it flips the pin again partway through a half-frame, so the reload lands on a non-zero bit index. Burst parking is reached the same way, by holding data_req low across the enable. The bench then raises and drops data_req while the bit clock is running.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int DIV_CODE_W  = 3;
    localparam int SWL_CODE_W  = 3;
    localparam int CHAN_CODE_W = 2;
    localparam int MAX_DIV_LOG = 4;
    localparam int MAX_SWL     = 256;
    localparam int DIV_CNT_W   = MAX_DIV_LOG;
    localparam int BIT_W       = $clog2(MAX_SWL);
    localparam int LEN_W       = BIT_W + 1;
    localparam int SLOT_W      = CHAN_CODE_W;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } afc_state_e;

    function automatic logic div_valid(input logic [DIV_CODE_W-1:0] code);
        return code <= DIV_CODE_W'(MAX_DIV_LOG);
    endfunction

    // last oversampling-edge count of one bit-clock half period
    function automatic logic [DIV_CNT_W-1:0] div_last(input logic [DIV_CODE_W-1:0] code);
        logic [DIV_CNT_W:0] n;
        n = (DIV_CNT_W+1)'(1) << code;
        return DIV_CNT_W'(n - 1'b1);
    endfunction

    function automatic logic [LEN_W-1:0] swl_len(input logic [SWL_CODE_W-1:0] code);
        logic [LEN_W-1:0] r;
        unique case (code)
            3'd0:    r = LEN_W'(8);
            3'd1:    r = LEN_W'(16);
            3'd2:    r = LEN_W'(32);
            3'd3:    r = LEN_W'(48);
            3'd4:    r = LEN_W'(64);
            3'd5:    r = LEN_W'(128);
            3'd6:    r = LEN_W'(256);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [LEN_W-1:0] slot_len(input logic [LEN_W-1:0] swl,
                                                   input logic [CHAN_CODE_W-1:0] chan);
        logic [LEN_W-1:0] r;
        unique case (chan)
            2'd0:    r = swl;
            2'd1:    r = swl >> 1;
            2'd2:    r = swl / LEN_W'(3);
            default: r = swl >> 2;
        endcase
        return r;
    endfunction

    function automatic logic cfg_valid(input logic [DIV_CODE_W-1:0]  dcode,
                                       input logic [SWL_CODE_W-1:0]  scode,
                                       input logic [CHAN_CODE_W-1:0] ccode);
        logic ok;
        ok = div_valid(dcode) && (swl_len(scode) != '0);
        if (ccode == 2'd2 && scode != 3'd3) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/afc_sync.sv
module afc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], d};
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/afc_bitclk.sv
module afc_bitclk
    import afc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  run,
    input  logic                  master,
    input  logic                  inv,
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic                  ovs_edge,
    input  logic                  pin_rise,
    input  logic                  pin_fall,
    output logic                  sck_gen,
    output logic                  smp_tick,
    output logic                  adv_tick
);
    logic [DIV_CNT_W-1:0] dcnt;
    logic                 sck_q;
    logic                 step;
    logic                 toggle;

    assign step   = master && run && ovs_edge;
    assign toggle = step && (dcnt == div_last(div_code));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt  <= '0;
            sck_q <= 1'b0;
        end else if (clr || !master) begin
            dcnt  <= '0;
            sck_q <= 1'b0;
        end else if (toggle) begin
            dcnt  <= '0;
            sck_q <= ~sck_q;
        end else if (step) begin
            dcnt  <= dcnt + 1'b1;
        end
    end

    // internal clock: rising = sample, falling = advance
    always_comb begin
        if (master) begin
            smp_tick = toggle && !sck_q;
            adv_tick = toggle &&  sck_q;
        end else begin
            smp_tick = inv ? pin_fall : pin_rise;
            adv_tick = inv ? pin_rise : pin_fall;
        end
    end

    assign sck_gen = sck_q;
endmodule

// File: rtl/afc_fsm.sv
module afc_fsm
    import afc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       cfg_ok,
    input  logic       sck_master,
    input  logic       ws_master,
    input  logic       burst_en,
    input  logic       data_req,
    input  logic       sck_gen,
    input  logic       ws_edge,
    output afc_state_e state,
    output logic       clk_en,
    output logic       clr,
    output logic       active,
    output logic       syncing,
    output logic       start_now
);
    afc_state_e state_nxt;
    logic       go;
    logic       hold_want;
    logic       park;

    assign go        = enable && cfg_ok;
    assign hold_want = burst_en && sck_master && !data_req;
    assign park      = hold_want && !sck_gen;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:  if (go)         state_nxt = ws_master ? ST_RUN : ST_SYNC;
            ST_SYNC: if (!go)        state_nxt = ST_OFF;
                     else if (ws_edge) state_nxt = ST_RUN;
            ST_RUN:  if (!go)        state_nxt = ST_OFF;
                     else if (park)  state_nxt = ST_HOLD;
            ST_HOLD: if (!go)        state_nxt = ST_OFF;
                     else if (!hold_want) state_nxt = ST_RUN;
            default:                 state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        clk_en    = 1'b0;
        clr       = 1'b0;
        active    = 1'b0;
        syncing   = 1'b0;
        start_now = 1'b0;
        unique case (state)
            ST_OFF: begin
                clr       = 1'b1;
                start_now = go && ws_master;
            end
            ST_SYNC: begin
                clk_en  = 1'b1;
                syncing = 1'b1;
            end
            ST_RUN: begin
                clk_en = !park;
                active = 1'b1;
            end
            ST_HOLD: begin
                clk_en = 1'b0;
            end
            default: clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/afc_frame.sv
module afc_frame
    import afc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   start_now,
    input  logic                   active,
    input  logic                   syncing,
    input  logic                   ws_master,
    input  logic                   ws_inv,
    input  logic                   ws_pin,
    input  logic                   adv_tick,
    input  logic                   smp_tick,
    input  logic [SWL_CODE_W-1:0]  swl_code,
    input  logic [CHAN_CODE_W-1:0] chan_code,
    output logic                   ws_gen,
    output logic                   ws_edge,
    output logic                   bit_strobe,
    output logic                   slot_start,
    output logic                   half_start,
    output logic                   half_id,
    output logic [SLOT_W-1:0]      slot_idx,
    output logic [BIT_W-1:0]       bit_idx
);
    logic [BIT_W-1:0]  bit_q;
    logic [BIT_W-1:0]  sbit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              half_q;
    logic              half_now;
    logic [LEN_W-1:0]  swl;
    logic [LEN_W-1:0]  slen;
    logic              last_bit;
    logic              last_sbit;

    assign half_now  = ~(ws_pin ^ ws_inv);
    assign swl       = swl_len(swl_code);
    assign slen      = slot_len(swl, chan_code);
    assign last_bit  = ({1'b0, bit_q}  == swl  - 1'b1);
    assign last_sbit = ({1'b0, sbit_q} == slen - 1'b1);
    assign ws_edge   = !ws_master && (active || syncing) && adv_tick && (half_now != half_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= '0;
            sbit_q     <= '0;
            slot_q     <= '0;
            half_q     <= 1'b0;
            bit_strobe <= 1'b0;
            slot_start <= 1'b0;
            half_start <= 1'b0;
        end else begin
            bit_strobe <= active && smp_tick;
            slot_start <= 1'b0;
            half_start <= 1'b0;
            if (clr && !start_now) begin
                bit_q  <= '0;
                sbit_q <= '0;
                slot_q <= '0;
                half_q <= ws_master ? 1'b0 : half_now;
            end else if (start_now) begin
                bit_q      <= '0;
                sbit_q     <= '0;
                slot_q     <= '0;
                half_q     <= 1'b0;
                half_start <= 1'b1;
                slot_start <= 1'b1;
            end else if (ws_edge) begin
                bit_q      <= '0;
                sbit_q     <= '0;
                slot_q     <= '0;
                half_q     <= half_now;
                half_start <= 1'b1;
                slot_start <= 1'b1;
            end else if (active && adv_tick) begin
                if (last_bit) begin
                    bit_q      <= '0;
                    sbit_q     <= '0;
                    slot_q     <= '0;
                    slot_start <= 1'b1;
                    if (ws_master) begin
                        half_q     <= ~half_q;
                        half_start <= 1'b1;
                    end
                end else begin
                    bit_q <= bit_q + 1'b1;
                    if (last_sbit) begin
                        sbit_q     <= '0;
                        slot_q     <= slot_q + 1'b1;
                        slot_start <= 1'b1;
                    end else begin
                        sbit_q <= sbit_q + 1'b1;
                    end
                end
            end
        end
    end

    assign ws_gen   = ws_master ? half_q : 1'b0;
    assign half_id  = half_q;
    assign slot_idx = slot_q;
    assign bit_idx  = bit_q;
endmodule

// File: rtl/audio_frame_clkgen.sv
module audio_frame_clkgen
    import afc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic [DIV_CODE_W-1:0]  div_code,
    input  logic [SWL_CODE_W-1:0]  swl_code,
    input  logic [CHAN_CODE_W-1:0] chan_code,
    input  logic                   sck_master,
    input  logic                   ws_master,
    input  logic                   sck_inv,
    input  logic                   ws_inv,
    input  logic                   burst_en,
    input  logic                   data_req,
    input  logic                   ovs_clk,
    input  logic                   sck_in,
    input  logic                   ws_in,
    output logic                   sck_out,
    output logic                   sck_oe,
    output logic                   ws_out,
    output logic                   ws_oe,
    output logic                   cfg_err,
    output logic                   bit_strobe,
    output logic                   slot_start,
    output logic                   half_start,
    output logic                   half_id,
    output logic [SLOT_W-1:0]      slot_idx,
    output logic [BIT_W-1:0]       bit_idx
);
    localparam int NPIN    = 3;
    localparam int PIN_OVS = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_WS  = 2;

    logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
    afc_state_e      state;
    logic            cfg_ok, clk_en, clr, active, syncing, start_now;
    logic            sck_gen, smp_tick, adv_tick, ws_gen, ws_edge;
    logic            unused_pins;

    assign pin_raw = {ws_in, sck_in, ovs_clk};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        afc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw[g]),
            .level (pin_lvl[g]),
            .rise  (pin_rise[g]),
            .fall  (pin_fall[g])
        );
    end

    assign unused_pins = ^{pin_lvl[PIN_OVS], pin_lvl[PIN_SCK], pin_rise[PIN_WS], pin_fall[PIN_WS]};
    assign cfg_ok      = cfg_valid(div_code, swl_code, chan_code);

    afc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_ok     (cfg_ok),
        .sck_master (sck_master),
        .ws_master  (ws_master),
        .burst_en   (burst_en),
        .data_req   (data_req),
        .sck_gen    (sck_gen),
        .ws_edge    (ws_edge),
        .state      (state),
        .clk_en     (clk_en),
        .clr        (clr),
        .active     (active),
        .syncing    (syncing),
        .start_now  (start_now)
    );

    afc_bitclk u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .run      (clk_en),
        .master   (sck_master),
        .inv      (sck_inv),
        .div_code (div_code),
        .ovs_edge (pin_rise[PIN_OVS] | pin_fall[PIN_OVS]),
        .pin_rise (pin_rise[PIN_SCK]),
        .pin_fall (pin_fall[PIN_SCK]),
        .sck_gen  (sck_gen),
        .smp_tick (smp_tick),
        .adv_tick (adv_tick)
    );

    afc_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .start_now  (start_now),
        .active     (active),
        .syncing    (syncing),
        .ws_master  (ws_master),
        .ws_inv     (ws_inv),
        .ws_pin     (pin_lvl[PIN_WS]),
        .adv_tick   (adv_tick),
        .smp_tick   (smp_tick),
        .swl_code   (swl_code),
        .chan_code  (chan_code),
        .ws_gen     (ws_gen),
        .ws_edge    (ws_edge),
        .bit_strobe (bit_strobe),
        .slot_start (slot_start),
        .half_start (half_start),
        .half_id    (half_id),
        .slot_idx   (slot_idx),
        .bit_idx    (bit_idx)
    );

    assign sck_out = sck_gen ^ sck_inv;
    assign sck_oe  = sck_master;
    assign ws_out  = ~(ws_gen ^ ws_inv);
    assign ws_oe   = ws_master;
    assign cfg_err = !cfg_ok;
endmodule

// File: rtl/afc_checker.sv
module afc_checker
    import afc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input afc_state_e             state,
    input logic                   ws_master,
    input logic                   ws_inv,
    input logic                   sck_inv,
    input logic                   ws_out,
    input logic                   sck_out,
    input logic                   sck_gen,
    input logic                   bit_strobe,
    input logic                   slot_start,
    input logic                   half_start,
    input logic [SWL_CODE_W-1:0]  swl_code,
    input logic [CHAN_CODE_W-1:0] chan_code,
    input logic [SLOT_W-1:0]      slot_idx,
    input logic [BIT_W-1:0]       bit_idx
);
    assert_bit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> ({1'b0, bit_idx} < swl_len(swl_code)));

    assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (slot_idx <= chan_code));

    assert_half_has_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        half_start |-> slot_start);

    assert_ws_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN && ws_master && $past(ws_master)
         && ws_inv == $past(ws_inv) && ws_out != $past(ws_out)) |-> half_start);

    assert_hold_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD && sck_inv == $past(sck_inv))
        |-> ($stable(sck_out) && !bit_strobe));

    assert_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && $past(state) == ST_OFF) |-> (!sck_gen && !bit_strobe && !half_start));

    assert_sync_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |-> (!bit_strobe && !half_start && !slot_start));
endmodule

bind audio_frame_clkgen afc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .ws_master  (ws_master),
    .ws_inv     (ws_inv),
    .sck_inv    (sck_inv),
    .ws_out     (ws_out),
    .sck_out    (sck_out),
    .sck_gen    (sck_gen),
    .bit_strobe (bit_strobe),
    .slot_start (slot_start),
    .half_start (half_start),
    .swl_code   (swl_code),
    .chan_code  (chan_code),
    .slot_idx   (slot_idx),
    .bit_idx    (bit_idx)
);

// File: tb/audio_frame_clkgen_bench.sv
`timescale 1ns/1ps
module audio_frame_clkgen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] div_code = 3'd0;
    logic [2:0] swl_code = 3'd0;
    logic [1:0] chan_code = 2'd0;
    logic       sck_master = 1'b1, ws_master = 1'b1, sck_inv = 1'b0, ws_inv = 1'b0;
    logic       burst_en = 1'b0, data_req = 1'b1;
    logic       ovs_clk = 1'b0, sck_in = 1'b0, ws_in = 1'b1;
    logic       sck_out, sck_oe, ws_out, ws_oe, cfg_err;
    logic       bit_strobe, slot_start, half_start, half_id;
    logic [1:0] slot_idx;
    logic [7:0] bit_idx;
    logic       ext_sck_on = 1'b0;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    audio_frame_clkgen u_audio_frame_clkgen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_code(div_code),
        .swl_code(swl_code), .chan_code(chan_code), .sck_master(sck_master),
        .ws_master(ws_master), .sck_inv(sck_inv), .ws_inv(ws_inv),
        .burst_en(burst_en), .data_req(data_req), .ovs_clk(ovs_clk),
        .sck_in(sck_in), .ws_in(ws_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .ws_out(ws_out), .ws_oe(ws_oe), .cfg_err(cfg_err),
        .bit_strobe(bit_strobe), .slot_start(slot_start), .half_start(half_start),
        .half_id(half_id), .slot_idx(slot_idx), .bit_idx(bit_idx)
    );

    // oversampling clock: one edge every 2 system cycles
    initial forever begin
        repeat (2) @(negedge clk);
        ovs_clk = ~ovs_clk;
    end

    // external bit clock, period 8 system cycles
    initial forever begin
        repeat (4) @(negedge clk);
        if (ext_sck_on) sck_in = ~sck_in;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int dc, input int sc, input int cc, input bit sm,
                         input bit wm, input bit si, input bit wi, input bit be);
        @(negedge clk);
        enable = 1'b0;
        repeat (6) @(negedge clk);
        div_code = 3'(dc); swl_code = 3'(sc); chan_code = 2'(cc);
        sck_master = sm; ws_master = wm; sck_inv = si; ws_inv = wi; burst_en = be;
        repeat (2) @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic count_rises(input int cycles, output int n);
        logic prev;
        n = 0;
        prev = sck_out;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sck_out && !prev) n++;
            prev = sck_out;
        end
    endtask

    task automatic sck_period(output int p);
        logic prev;
        int   k;
        p = -1;
        prev = sck_out;
        k = 0;
        while (k < 400) begin
            @(negedge clk);
            k++;
            if (sck_out && !prev) break;
            prev = sck_out;
        end
        prev = sck_out;
        for (int i = 1; i < 400; i++) begin
            @(negedge clk);
            if (sck_out && !prev) begin p = i; break; end
            prev = sck_out;
        end
    endtask

    task automatic bits_per_half(output int n, output int max_idx);
        logic pw, ps;
        n = -1; max_idx = 0;
        pw = ws_out;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (ws_out != pw) break;
        end
        pw = ws_out; ps = sck_out; n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (ws_out != pw) break;
            if (sck_out && !ps) n++;
            if (int'(bit_idx) > max_idx) max_idx = int'(bit_idx);
            ps = sck_out;
        end
    endtask

    task automatic wait_half(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (half_start) begin seen = 1'b1; break; end
        end
    endtask

    task automatic t_reset_idle;
        @(negedge clk);
        check(sck_out == 1'b0 && ws_out == 1'b1 && !bit_strobe && !half_start,
              "R10 reset idle", {sck_out, ws_out}, 1);
    endtask

    task automatic t_divider;
        int p;
        for (int c = 0; c <= 4; c++) begin
            setup(c, 0, 0, 1, 1, 0, 0, 0);
            sck_period(p);
            check(p == 4 * (1 << c), "R1 bit clock period", p, 4 * (1 << c));
        end
    endtask

    task automatic t_invalid;
        int n;
        setup(5, 0, 0, 1, 1, 0, 0, 0);
        @(negedge clk);
        count_rises(200, n);
        check(cfg_err && n == 0 && ws_out == 1'b1, "R2 divider code 5", n, 0);
        setup(1, 7, 0, 1, 1, 0, 0, 0);
        count_rises(100, n);
        check(cfg_err && n == 0, "R2 length code 7", n, 0);
        setup(0, 0, 2, 1, 1, 0, 0, 0);
        count_rises(100, n);
        check(cfg_err && n == 0, "R2 three slots at 8 bits", n, 0);
        setup(0, 3, 2, 1, 1, 0, 0, 0);
        check(!cfg_err, "R2 three slots at 48 bits valid", cfg_err, 0);
    endtask

    task automatic t_length;
        int n, mx;
        int codes[4] = '{0, 1, 3, 6};
        int lens[4]  = '{8, 16, 48, 256};
        for (int i = 0; i < 4; i++) begin
            setup(0, codes[i], 0, 1, 1, 0, 0, 0);
            bits_per_half(n, mx);
            check(n == lens[i], "R3 bits per half", n, lens[i]);
            check(mx == lens[i] - 1, "R3 top bit index", mx, lens[i] - 1);
        end
    endtask

    task automatic t_slots(input int sc, input int cc, input int exp_slots);
        bit seen;
        int n, mx;
        setup(0, sc, cc, 1, 1, 0, 0, 0);
        wait_half(2000, seen);
        n = 1; mx = int'(slot_idx);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (half_start) break;
            if (slot_start) n++;
            if (int'(slot_idx) > mx) mx = int'(slot_idx);
        end
        check(seen && n == exp_slots, "R4 slots per half", n, exp_slots);
        check(mx == exp_slots - 1, "R4 top slot index", mx, exp_slots - 1);
    endtask

    task automatic t_polarity;
        int  bad;
        bit  seen;
        setup(0, 0, 0, 1, 1, 1, 1, 0);
        @(negedge clk);
        check(sck_out == 1'b1, "R5 inverted idle high", sck_out, 1);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bit_strobe && sck_out != 1'b0) bad++;
        end
        check(bad == 0, "R5 sample on falling pin edge", bad, 0);
        setup(0, 0, 0, 1, 1, 1, 1, 0);
        wait_half(50, seen);
        check(seen && ws_out == 1'b0 && half_id == 1'b0, "R6 inverted first half low", ws_out, 0);
        wait_half(200, seen);
        check(seen && ws_out == 1'b1 && half_id == 1'b1, "R6 inverted second half high", ws_out, 1);
        setup(0, 0, 0, 1, 1, 0, 0, 0);
        wait_half(50, seen);
        check(seen && ws_out == 1'b1 && bit_idx == 8'd0, "R10 restart first half bit 0", ws_out, 1);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bit_strobe && sck_out != 1'b1) bad++;
        end
        check(bad == 0, "R5 sample on rising pin edge", bad, 0);
    endtask

    task automatic t_burst;
        int n, s;
        data_req = 1'b0;
        setup(0, 1, 0, 1, 1, 0, 0, 1);
        s = 0;
        count_rises(200, n);
        check(n == 0 && sck_out == 1'b0, "R7 parked while no data", n, 0);
        data_req = 1'b1;
        count_rises(100, n);
        check(n >= 20 && n <= 26, "R7 runs with data", n, 25);
        data_req = 1'b0;
        repeat (10) @(negedge clk);
        count_rises(100, n);
        for (int i = 0; i < 50; i++) begin @(negedge clk); if (bit_strobe) s++; end
        check(n == 0 && s == 0, "R7 parks again", n + s, 0);
        setup(0, 1, 0, 1, 1, 0, 0, 0);
        count_rises(100, n);
        check(n >= 24, "R7 data_req ignored without burst", n, 25);
        data_req = 1'b1;
    endtask

    task automatic t_slave_sck;
        int s;
        logic so;
        setup(0, 1, 0, 0, 1, 0, 0, 0);
        ext_sck_on = 1'b1;
        repeat (40) @(negedge clk);
        so = sck_out;
        s = 0;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if (bit_strobe) s++;
            if (sck_out != so) s = -1000;
        end
        check(!sck_oe && s >= 19 && s <= 21, "R8 strobes follow pin", s, 20);
        ext_sck_on = 1'b0;
    endtask

    task automatic t_slave_ws;
        int  s;
        bit  seen;
        ws_in = 1'b1;
        setup(0, 2, 0, 1, 0, 0, 0, 0);
        s = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bit_strobe || half_start || slot_start) s++;
        end
        check(s == 0 && !ws_oe && ws_out == 1'b1, "R9 quiet until first edge", s, 0);
        ws_in = 1'b0;
        wait_half(40, seen);
        check(seen && half_id == 1'b1 && bit_idx == 8'd0, "R9 locks on edge", half_id, 1);
        s = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (bit_strobe) s++; end
        check(s >= 9 && bit_idx != 8'd0, "R9 counting after lock", s, 10);
        ws_in = 1'b1;
        wait_half(40, seen);
        check(seen && half_id == 1'b0 && bit_idx == 8'd0, "R9 reload on mid-half edge", bit_idx, 0);
    endtask

    task automatic t_disable;
        int s;
        setup(0, 0, 0, 1, 1, 0, 0, 0);
        repeat (30) @(negedge clk);
        enable = 1'b0;
        repeat (4) @(negedge clk);
        s = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (bit_strobe || half_start || sck_out || !ws_out) s++;
        end
        check(s == 0, "R10 idle while disabled", s, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_divider();
        t_invalid();
        t_length();
        t_slots(4, 3, 4);
        t_slots(3, 2, 3);
        t_slots(2, 1, 2);
        t_polarity();
        t_burst();
        t_slave_sck();
        t_slave_ws();
        t_disable();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule